// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Distributor

This block gathers level-sensitive interrupt lines and steers each of them to a set of CPUs in a small multiprocessor. For every source it keeps a global enable and a routing bitmap of target CPUs. Each CPU has its own mask over all sources. Software reaches these controls through a simple register bus. The bus carries a CPU index, so one address window serves every processor and accesses to the mask and acknowledge registers act on the CPU that issued them.

Enables and masks are never updated by read-modify-write. Software writes a source number to a "set" register or to a "clear" register, so two processors cannot race on a shared bitmap. A CPU that sees its interrupt line high reads its acknowledge register. That read returns the lowest-numbered source pending for that CPU as a 10-bit ID. ID 0 means a doorbell (inter-processor) event and 1023 means nothing is pending. Source 5 is a private per-CPU timer. Only the per-CPU mask gates it: its routing word and its global enable have no effect.

Top module: `mcpu_irq_dist`

## Requirements
- R1: After reset every global enable is clear, every per-CPU mask bit is set and every routing word is zero. Every acknowledge read returns 1023 and every `cpu_irq` bit is low.
- R2: A read at 0x000 returns the number of supported sources (32) in bits [11:2]. All other bits of that word are zero.
- R3: Writing source number n to 0x030 sets the global enable of n, and writing n to 0x034 clears it. A written value of 32 or more changes no enable.
- R4: Writing n to 0x048 masks source n for the CPU given on `bus_cpu`, and writing n to 0x04C unmasks it. The masks of the other CPUs are unchanged. A value of 32 or more changes nothing.
- R5: The routing word of source n is at 0x100 + 4n. Bit c of that word routes the source to CPU c. It can be written and read back. Bits above the CPU count read as zero.
- R6: A source n other than 0 and 5 is pending for CPU c exactly when four conditions hold: its input is high, its global enable is set, routing bit c is set, and CPU c has not masked it.
- R7: Source 5 is pending for CPU c exactly when its input is high and CPU c has not masked it, whatever its enable and routing word hold.
- R8: A read at 0x044 returns, in bits [9:0], the lowest-numbered source pending for the CPU on `bus_cpu`. It returns 1023 when none is pending. Bits [31:10] are zero.
- R9: While `doorbell_req[c]` is high, an acknowledge read by CPU c returns 0, ahead of any source. The source 0 input never makes anything pending.
- R10: `cpu_irq[c]` is high exactly when an acknowledge read by CPU c would return a value other than 1023.
- R11: An acknowledge read has no side effect. Repeated reads with unchanged inputs return the same ID.
- R12: Read data appears on `bus_rdata` in the cycle after the read strobe. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_cpu | input | 2 | Index of the CPU issuing the access |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| src_lvl | input | 32 | Level-sensitive source inputs |
| doorbell_req | input | 4 | Per-CPU doorbell pending flags |
| cpu_irq | output | 4 | Per-CPU interrupt request |

## Verification
The bench attacks priority order with several sources active at once. A design that searched from the wrong end, or let a doorbell lose to a source, would return the wrong ID. It writes out-of-range source numbers such as 35. A design that truncated the number would silently enable source 3. It checks that a mask write reaches only the issuing CPU, and that the timer source fires with a zero routing word and a cleared enable. A design that treated the timer like the other sources would stay silent there. Random mixes of enable, mask, routing, level and doorbell changes are compared after every step against a model of the acknowledge value and of each `cpu_irq` line.

// File: rtl/irq_dist_pkg.sv
// Package: register offsets and ID encodings shared by the distributor.
// Assumes a 12-bit byte address space and 32-bit data words.
package irq_dist_pkg;
    localparam int          ADDR_W         = 12;
    localparam int          DATA_W         = 32;
    localparam int          ID_W           = 10;
    localparam logic [11:0] OFS_CTRL       = 12'h000;
    localparam logic [11:0] OFS_EN_SET     = 12'h030;
    localparam logic [11:0] OFS_EN_CLR     = 12'h034;
    localparam logic [11:0] OFS_ACK        = 12'h044;
    localparam logic [11:0] OFS_MSK_SET    = 12'h048;
    localparam logic [11:0] OFS_MSK_CLR    = 12'h04C;
    localparam logic [11:0] OFS_ROUTE_BASE = 12'h100;
    localparam logic [9:0]  ID_NONE        = 10'd1023;
    localparam logic [9:0]  ID_DOORBELL    = 10'd0;
endpackage

// File: rtl/irq_cfg_regs.sv
// Module: configuration state of the distributor. It holds the global enables,
// the per-CPU masks and the per-source routing words. Enables and masks change
// by writing a source number to separate set or clear offsets; numbers out of
// range are dropped. Assumes one write per cycle.
module irq_cfg_regs
    import irq_dist_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int NUM_SRC  = 32,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [CPU_W-1:0]                     wr_cpu,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [NUM_SRC-1:0]                   en_q,
    output logic [NUM_CPUS-1:0][NUM_SRC-1:0]     mask_q,
    output logic [NUM_SRC-1:0][NUM_CPUS-1:0]     route_q
);
    logic             num_ok;
    logic [SRC_W-1:0] num;

    // Decode the written source number and check that it is in range.
    always_comb begin
        num_ok = (wr_data < DATA_W'(NUM_SRC));
        num    = wr_data[SRC_W-1:0];
    end

    // Global enables: set/clear by source number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && num_ok) begin
            if (wr_addr == OFS_EN_SET)      en_q[num] <= 1'b1;
            else if (wr_addr == OFS_EN_CLR) en_q[num] <= 1'b0;
        end
    end

    // Per-CPU masks: set/clear by source number for the issuing CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en && num_ok && (32'(wr_cpu) < NUM_CPUS)) begin
            if (wr_addr == OFS_MSK_SET)      mask_q[wr_cpu][num] <= 1'b1;
            else if (wr_addr == OFS_MSK_CLR) mask_q[wr_cpu][num] <= 1'b0;
        end
    end

    // Routing words: one register per source at its own address.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_route
        localparam logic [ADDR_W-1:0] RADDR = OFS_ROUTE_BASE + ADDR_W'(4 * n);
        // Capture the CPU bitmap when this source's word is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                           route_q[n] <= '0;
            else if (wr_en && wr_addr == RADDR)   route_q[n] <= wr_data[NUM_CPUS-1:0];
        end
    end

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_EN_SET && num_ok) |=> en_q[$past(num)]);
    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_EN_CLR && num_ok) |=> !en_q[$past(num)]);
    // R3
    en_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !num_ok) |=> $stable(en_q));
    // R4
    msk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_MSK_SET && num_ok) |=> mask_q[$past(wr_cpu)][$past(num)]);
    // R4
    msk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_MSK_CLR && num_ok) |=> !mask_q[$past(wr_cpu)][$past(num)]);
endmodule

// File: rtl/irq_cpu_select.sv
// Module: per-CPU pending logic and lowest-number priority pick. Source 0 never
// pends (its ID is reserved for doorbells). The timer source obeys only the
// CPU's mask. Purely combinational; clk/rst_n feed the assertions only.
module irq_cpu_select
    import irq_dist_pkg::*;
#(
    parameter int NUM_CPUS  = 4,
    parameter int NUM_SRC   = 32,
    parameter int TIMER_SRC = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               src_lvl,
    input  logic [NUM_SRC-1:0]               en_q,
    input  logic [NUM_CPUS-1:0][NUM_SRC-1:0] mask_q,
    input  logic [NUM_SRC-1:0][NUM_CPUS-1:0] route_q,
    input  logic [NUM_CPUS-1:0]              doorbell,
    output logic [NUM_CPUS-1:0][ID_W-1:0]    ack_id,
    output logic [NUM_CPUS-1:0]              irq_out
);
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic [NUM_SRC-1:0] pend;

        // Build the pending vector of this CPU.
        always_comb begin
            for (int n = 0; n < NUM_SRC; n++) begin
                if (n == 0)
                    pend[n] = 1'b0;
                else if (n == TIMER_SRC)
                    pend[n] = src_lvl[n] & ~mask_q[c][n];
                else
                    pend[n] = src_lvl[n] & en_q[n] & route_q[n][c] & ~mask_q[c][n];
            end
        end

        // Pick the lowest pending number; a doorbell wins over all sources.
        always_comb begin
            ack_id[c] = ID_NONE;
            for (int n = NUM_SRC - 1; n >= 1; n--)
                if (pend[n]) ack_id[c] = ID_W'(n);
            if (doorbell[c]) ack_id[c] = ID_DOORBELL;
        end

        // Request line follows any pending work.
        always_comb irq_out[c] = doorbell[c] | (|pend);

        // R8
        lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_id[c] != ID_NONE && ack_id[c] != ID_DOORBELL) |->
            (pend[ack_id[c]] && ((pend & ~({NUM_SRC{1'b1}} << ack_id[c])) == '0)));
        // R10
        irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[c] == (ack_id[c] != ID_NONE));
        // R9
        doorbell_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            doorbell[c] |-> (ack_id[c] == ID_DOORBELL));
    end
endmodule

// File: rtl/mcpu_irq_dist.sv
// Module: top of the multi-CPU interrupt distributor. It ties the configuration
// registers and the per-CPU selectors to the register bus, and drives the
// registered read data. Assumes reads and writes never share a cycle.
module mcpu_irq_dist
    import irq_dist_pkg::*;
#(
    parameter int NUM_CPUS  = 4,
    parameter int NUM_SRC   = 32,
    parameter int TIMER_SRC = 5,
    localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [CPU_W-1:0]    bus_cpu,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0]  src_lvl,
    input  logic [NUM_CPUS-1:0] doorbell_req,
    output logic [NUM_CPUS-1:0] cpu_irq
);
    logic [NUM_SRC-1:0]               en_q;
    logic [NUM_CPUS-1:0][NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0][NUM_CPUS-1:0] route_q;
    logic [NUM_CPUS-1:0][ID_W-1:0]    ack_id;
    logic [5:0]                       ridx;
    logic                             route_hit;

    irq_cfg_regs #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
        .wr_cpu(bus_cpu), .wr_data(bus_wdata),
        .en_q(en_q), .mask_q(mask_q), .route_q(route_q)
    );

    irq_cpu_select #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .TIMER_SRC(TIMER_SRC)) u_sel (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .en_q(en_q), .mask_q(mask_q),
        .route_q(route_q), .doorbell(doorbell_req), .ack_id(ack_id), .irq_out(cpu_irq)
    );

    // Decode whether the address falls on a routing word.
    always_comb begin
        ridx      = bus_addr[7:2];
        route_hit = (bus_addr[11:8] == OFS_ROUTE_BASE[11:8]) && (bus_addr[1:0] == 2'b00)
                    && (32'(ridx) < NUM_SRC);
    end

    // Registered read mux: data is valid the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (bus_addr == OFS_CTRL)
                bus_rdata <= DATA_W'({ID_W'(NUM_SRC), 2'b00});
            else if (bus_addr == OFS_ACK)
                bus_rdata <= DATA_W'(ack_id[bus_cpu]);
            else if (route_hit)
                bus_rdata <= DATA_W'(route_q[ridx[SRC_W-1:0]]);
            else
                bus_rdata <= '0;
        end
    end

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_CTRL) |=> (bus_rdata[11:2] == ID_W'(NUM_SRC)));
    // R8
    ack_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_ACK) |=> (bus_rdata[DATA_W-1:ID_W] == '0));
    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 12'h008) |=> (bus_rdata == '0));
endmodule

// File: tb/mcpu_irq_dist_bench.sv
`timescale 1ns/1ps
module mcpu_irq_dist_bench;
    localparam int NC = 4;
    localparam int NS = 32;
    localparam int TMR = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_cpu = '0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_lvl = '0;
    logic [3:0]  doorbell_req = '0;
    logic [3:0]  cpu_irq;

    int n_chk = 0;
    int n_bad = 0;

    // Model state built from the requirements.
    bit [31:0] m_en;
    bit [31:0] m_msk [NC];
    bit [3:0]  m_rt  [NS];

    always #2 clk = ~clk;

    mcpu_irq_dist u_mcpu_irq_dist (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_lvl(src_lvl), .doorbell_req(doorbell_req), .cpu_irq(cpu_irq)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ack(int c);
        if (doorbell_req[c]) return 0;
        for (int n = 1; n < NS; n++) begin
            if (n == TMR) begin
                if (src_lvl[n] && !m_msk[c][n]) return n;
            end else if (src_lvl[n] && m_en[n] && m_rt[n][c] && !m_msk[c][n]) begin
                return n;
            end
        end
        return 1023;
    endfunction

    task automatic wr(int cpu, logic [11:0] addr, logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_cpu = 2'(cpu); bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
        if (data < NS) begin
            case (addr)
                12'h030: m_en[data[4:0]] = 1'b1;
                12'h034: m_en[data[4:0]] = 1'b0;
                12'h048: m_msk[cpu][data[4:0]] = 1'b1;
                12'h04C: m_msk[cpu][data[4:0]] = 1'b0;
                default: ;
            endcase
        end
        if (addr >= 12'h100 && addr < 12'h180 && addr[1:0] == 2'b00)
            m_rt[addr[6:2]] = data[3:0];
    endtask

    task automatic rd(int cpu, logic [11:0] addr, output int val);
        @(negedge clk);
        bus_rd = 1'b1; bus_cpu = 2'(cpu); bus_addr = addr;
        @(negedge clk);
        bus_rd = 1'b0;
        val = int'(bus_rdata);
    endtask

    task automatic check_all_cpus(string req);
        int v;
        for (int c = 0; c < NC; c++) begin
            rd(c, 12'h044, v);
            chk(req, v, exp_ack(c));
            chk("R10", int'(cpu_irq[c]), (exp_ack(c) != 1023) ? 1 : 0);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v, v2;
        void'($urandom(32'd4711));
        m_en = '0;
        for (int c = 0; c < NC; c++) m_msk[c] = '1;
        for (int n = 0; n < NS; n++) m_rt[n] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        src_lvl = '1;
        // R1: everything masked and disabled out of reset
        #1;
        chk("R1 irq", int'(cpu_irq), 0);
        check_all_cpus("R1");
        // R2: source count field
        rd(0, 12'h000, v);
        chk("R2", v, 32 << 2);
        // R12: unmapped address
        rd(0, 12'h008, v);
        chk("R12", v, 0);
        // R5: route readback, upper bits zero
        wr(0, 12'h100 + 4 * 7, 32'hFFFF_FFF5);
        rd(0, 12'h100 + 4 * 7, v);
        chk("R5", v, 5);
        wr(0, 12'h100 + 4 * 7, 0);
        // R6: routed, enabled, unmasked source reaches only its CPU
        wr(0, 12'h030, 3);
        wr(0, 12'h100 + 4 * 3, 32'h2);
        wr(1, 12'h04C, 3);
        wr(0, 12'h04C, 3);
        rd(1, 12'h044, v); chk("R6", v, 3);
        rd(0, 12'h044, v); chk("R6", v, 1023);
        // R8: lowest number wins
        wr(0, 12'h030, 9);
        wr(0, 12'h100 + 4 * 9, 32'h2);
        wr(1, 12'h04C, 9);
        rd(1, 12'h044, v); chk("R8", v, 3);
        // R3: clear enable, then out-of-range set must not alias to 3
        wr(0, 12'h034, 3);
        rd(1, 12'h044, v); chk("R3", v, 9);
        wr(0, 12'h030, 35);
        rd(1, 12'h044, v); chk("R3", v, 9);
        // R4: mask for CPU1 only
        wr(1, 12'h048, 9);
        rd(1, 12'h044, v); chk("R4", v, 1023);
        wr(3, 12'h04C, 9);
        wr(3, 12'h04C, 41);
        rd(3, 12'h044, v); chk("R4", v, 1023);
        wr(0, 12'h100 + 4 * 9, 32'hA);
        rd(3, 12'h044, v); chk("R4", v, 9);
        rd(1, 12'h044, v); chk("R4", v, 1023);
        // R7: timer ignores enable and routing
        wr(0, 12'h034, 5);
        wr(2, 12'h04C, 5);
        rd(2, 12'h044, v); chk("R7", v, 5);
        // R9: doorbell wins, source 0 never pends
        doorbell_req = 4'b0100;
        rd(2, 12'h044, v); chk("R9", v, 0);
        doorbell_req = '0;
        wr(0, 12'h030, 0);
        wr(0, 12'h100, 32'h1);
        wr(0, 12'h04C, 0);
        rd(0, 12'h044, v); chk("R9", v, 1023);
        // R11: repeated acknowledge reads are identical
        rd(2, 12'h044, v);
        rd(2, 12'h044, v2);
        chk("R11", v2, v);
        check_all_cpus("R8");
        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op, num, cpu;
            op  = $urandom_range(0, 6);
            num = $urandom_range(0, 39);
            cpu = $urandom_range(0, 3);
            case (op)
                0: wr(cpu, 12'h030, num);
                1: wr(cpu, 12'h034, num);
                2: wr(cpu, 12'h048, num);
                3: wr(cpu, 12'h04C, num);
                4: wr(cpu, 12'h100 + 12'(4 * (num % NS)), $urandom);
                5: begin @(negedge clk); src_lvl = $urandom; end
                default: begin @(negedge clk); doorbell_req = 4'($urandom); end
            endcase
            check_all_cpus("R6");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule